// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used page translations so that most virtual addresses can be turned into physical addresses without walking the page tables in memory. Every entry pairs a virtual page number with a physical frame base. It also holds the page's access-permission code and two memory attributes: one marks the page as cacheable and one marks it as bufferable for writes. Any translation may be placed in any entry. A lookup compares the requested page number against all entries in parallel. Pages are 4 KB, so the low 12 address bits pass straight through and only the upper 20 bits are replaced.

The lookup port runs every cycle. A registered result (hit, physical address, permission and attributes) appears one clock edge after the address is presented. An external walker loads new translations through the refill port after a miss. Refill uses a free entry when one exists; otherwise it evicts the entry named by a rotating pointer. When the operating system switches to a task whose virtual addresses may overlap those of the previous task, the flush input drops every translation at once.

Top module: `xlat_cache`

## Requirements
- R1: Synchronous active-high reset marks every entry empty, sets the rotating pointer to entry 0 and drives all lookup outputs to zero.
- R2: The buffer holds 64 translations at once, each in any entry, and all 64 distinct page numbers hit together once loaded.
- R3: A lookup whose `lk_va[31:12]` matches a valid entry drives, after the next rising edge, `lk_hit`=1, `lk_pa`={stored frame, `lk_va[11:0]`}, and the stored permission, cacheable and bufferable values.
- R4: A lookup that matches no valid entry drives, after the next rising edge, `lk_hit`=0 and zero on `lk_pa`, `lk_ap`, `lk_c` and `lk_b`.
- R5: A refill is seen by lookups from the edge after the one that writes it. A lookup at the same edge still sees the old contents. Refills go into empty entries, lowest index first, before any valid entry is evicted.
- R6: When no entry is empty, a refill replaces the entry named by the rotating pointer. The pointer moves up by one (wrapping 63 to 0) after every refill and returns to 0 on flush or reset.
- R7: A refill whose page number is already held overwrites that entry in place, so at most one entry ever matches a lookup.
- R8: A flush empties every entry, so every later lookup misses until refilled. A flush wins over a refill in the same cycle, and that refill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| rf_en | input | 1 | Write a translation this cycle |
| rf_vpn | input | 20 | Virtual page number of the new translation |
| rf_pfn | input | 20 | Physical frame base of the new translation |
| rf_ap | input | 2 | Access-permission code |
| rf_c | input | 1 | Cacheable attribute |
| rf_b | input | 1 | Bufferable attribute |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Registered: translation found |
| lk_pa | output | 32 | Registered physical address, zero on miss |
| lk_ap | output | 2 | Registered permission code, zero on miss |
| lk_c | output | 1 | Registered cacheable attribute, zero on miss |
| lk_b | output | 1 | Registered bufferable attribute, zero on miss |

## Verification
A lookup result is due exactly one rising edge after its address is applied. A refill or flush changes the contents at its own edge, so its effect first shows on outputs two edges after it is applied. The reference model in the bench forms the expected result at each edge from the inputs and the contents before that edge's update. It compares that result at the following falling edge, so every expectation carries the same one-edge delay. Directed lookups drive an address at a falling edge and read the outputs at the next falling edge. Refill-then-lookup sequences include the same-edge case to pin down the extra edge of delay.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PAGE_OFS_W = 12;

  function automatic int unsigned bump_wrap(input int unsigned cur, input int unsigned limit);
    return (cur + 1 >= limit) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N   = 64,
  parameter int KEY_W = 20
) (
  input  logic [N-1:0]     valid,
  input  logic [KEY_W-1:0] tags [N],
  input  logic [KEY_W-1:0] key,
  output logic [N-1:0]     match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fire,
  input  logic [N-1:0]     valid,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign slot = any_free ? free_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr_q <= '0;
    end else if (fire) begin
      ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int AP_W    = 2,
  localparam int OFS_W  = xlat_pkg::PAGE_OFS_W,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PFN_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             rf_en,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PFN_W-1:0] rf_pfn,
  input  logic [AP_W-1:0]  rf_ap,
  input  logic             rf_c,
  input  logic             rf_b,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_pa,
  output logic [AP_W-1:0]  lk_ap,
  output logic             lk_c,
  output logic             lk_b
);
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [AP_W-1:0]    ap_q  [ENTRIES];
  logic [ENTRIES-1:0] c_q;
  logic [ENTRIES-1:0] b_q;
  logic [ENTRIES-1:0] valid_q;

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] rf_match;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   dup_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_fire;

  xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_lk_cam (
    .valid(valid_q), .tags(tag_q), .key(lk_va[VA_W-1:OFS_W]), .match(lk_match)
  );

  xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_rf_cam (
    .valid(valid_q), .tags(tag_q), .key(rf_vpn), .match(rf_match)
  );

  assign wr_fire = rf_en && !flush;

  xlat_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .flush(flush), .fire(wr_fire),
    .valid(valid_q), .slot(victim_idx)
  );

  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rf_match[i]) dup_idx = IDX_W'(i);
    end
  end

  assign wr_idx = (|rf_match) ? dup_idx : victim_idx;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
    end else if (rf_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      tag_q[wr_idx] <= rf_vpn;
      pfn_q[wr_idx] <= rf_pfn;
      ap_q[wr_idx]  <= rf_ap;
      c_q[wr_idx]   <= rf_c;
      b_q[wr_idx]   <= rf_b;
    end
  end

  logic [PFN_W-1:0] sel_pfn;
  logic [AP_W-1:0]  sel_ap;
  logic             sel_c;
  logic             sel_b;

  always_comb begin
    sel_pfn = '0;
    sel_ap  = '0;
    sel_c   = 1'b0;
    sel_b   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_pfn = sel_pfn | pfn_q[i];
        sel_ap  = sel_ap  | ap_q[i];
        sel_c   = sel_c   | c_q[i];
        sel_b   = sel_b   | b_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit <= 1'b0;
      lk_pa  <= '0;
      lk_ap  <= '0;
      lk_c   <= 1'b0;
      lk_b   <= 1'b0;
    end else begin
      lk_hit <= |lk_match;
      lk_pa  <= (|lk_match) ? {sel_pfn, lk_va[OFS_W-1:0]} : '0;
      lk_ap  <= sel_ap;
      lk_c   <= sel_c;
      lk_b   <= sel_b;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int AP_W    = 2,
  parameter int OFS_W   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               rf_en,
  input logic [VA_W-OFS_W-1:0] rf_vpn,
  input logic [PA_W-OFS_W-1:0] rf_pfn,
  input logic [VA_W-1:0]    lk_va,
  input logic               lk_hit,
  input logic [PA_W-1:0]    lk_pa,
  input logic [AP_W-1:0]    lk_ap,
  input logic               lk_c,
  input logic               lk_b,
  input logic [ENTRIES-1:0] lk_match
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lk_hit && lk_pa == '0));

  p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_pa == '0 && lk_ap == '0 && !lk_c && !lk_b));

  p_refill_visible_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(rf_en, 2) && !$past(flush, 2) && !$past(rst, 2) && !$past(rst) &&
     $past(lk_va[VA_W-1:OFS_W]) == $past(rf_vpn, 2))
    |-> (lk_hit && lk_pa[PA_W-1:OFS_W] == $past(rf_pfn, 2)));

  p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(flush, 2) && !$past(rf_en) && !$past(rst)) |-> !lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .AP_W(AP_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .rf_en(rf_en), .rf_vpn(rf_vpn),
  .rf_pfn(rf_pfn), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
  .lk_ap(lk_ap), .lk_c(lk_c), .lk_b(lk_b), .lk_match(lk_match)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        rf_en = 1'b0;
  logic [19:0] rf_vpn = '0;
  logic [19:0] rf_pfn = '0;
  logic [1:0]  rf_ap = '0;
  logic        rf_c = 1'b0;
  logic        rf_b = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic [1:0]  lk_ap;
  logic        lk_c;
  logic        lk_b;

  xlat_cache u_dut (
    .clk(clk), .rst(rst), .flush(flush), .rf_en(rf_en), .rf_vpn(rf_vpn),
    .rf_pfn(rf_pfn), .rf_ap(rf_ap), .rf_c(rf_c), .rf_b(rf_b), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_ap(lk_ap), .lk_c(lk_c), .lk_b(lk_b)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference model
  bit [19:0] m_tag [N];
  bit [19:0] m_pfn [N];
  bit [1:0]  m_ap  [N];
  bit        m_c   [N];
  bit        m_b   [N];
  bit        m_v   [N];
  int        m_ptr = 0;
  bit        e_hit = 0;
  bit [31:0] e_pa = 0;
  bit [1:0]  e_ap = 0;
  bit        e_c = 0, e_b = 0;
  bit        armed = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_ptr = 0;
      e_hit = 0; e_pa = 0; e_ap = 0; e_c = 0; e_b = 0;
    end else begin
      int slot;
      e_hit = 0; e_pa = 0; e_ap = 0; e_c = 0; e_b = 0;
      foreach (m_v[i]) if (m_v[i] && m_tag[i] == lk_va[31:12]) begin
        e_hit = 1; e_pa = {m_pfn[i], lk_va[11:0]};
        e_ap = m_ap[i]; e_c = m_c[i]; e_b = m_b[i];
      end
      if (flush) begin
        foreach (m_v[i]) m_v[i] = 0;
        m_ptr = 0;
      end else if (rf_en) begin
        slot = -1;
        foreach (m_v[i]) if (slot < 0 && m_v[i] && m_tag[i] == rf_vpn) slot = i;
        foreach (m_v[i]) if (slot < 0 && !m_v[i]) slot = i;
        if (slot < 0) slot = m_ptr;
        m_v[slot] = 1; m_tag[slot] = rf_vpn; m_pfn[slot] = rf_pfn;
        m_ap[slot] = rf_ap; m_c[slot] = rf_c; m_b[slot] = rf_b;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (lk_hit !== e_hit || lk_pa !== e_pa || lk_ap !== e_ap ||
          lk_c !== e_c || lk_b !== e_b) begin
        errors++;
        $display("FAIL %s model: act hit=%0d pa=%h ap=%0d c=%0d b=%0d exp hit=%0d pa=%h ap=%0d c=%0d b=%0d",
                 e_hit ? "R3" : "R4", lk_hit, lk_pa, lk_ap, lk_c, lk_b,
                 e_hit, e_pa, e_ap, e_c, e_b);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic refill(input bit [19:0] vpn, input bit [19:0] pfn, input bit [1:0] ap,
                        input bit c, input bit b);
    @(negedge clk);
    rf_en = 1; rf_vpn = vpn; rf_pfn = pfn; rf_ap = ap; rf_c = c; rf_b = b;
    @(negedge clk);
    rf_en = 0;
  endtask

  task automatic look(input bit [31:0] va, output bit hit, output bit [31:0] pa);
    @(negedge clk);
    lk_va = va;
    @(negedge clk);
    hit = lk_hit; pa = lk_pa;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  function automatic bit [19:0] vp(input int i);
    return 20'h10000 + 20'(i * 37);
  endfunction
  function automatic bit [19:0] fr(input int i);
    return 20'h80000 + 20'(i * 5);
  endfunction

  initial begin
    bit hit;
    bit [31:0] pa;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: after reset nothing hits
    look(32'h1234_5678, hit, pa);
    check(!hit && pa == 0, "R1 reset lookup", {hit, pa}, 0);

    // R5: same-edge refill invisible, next edge visible
    @(negedge clk);
    rf_en = 1; rf_vpn = 20'h00ABC; rf_pfn = 20'h55555; rf_ap = 2'd3; rf_c = 1; rf_b = 0;
    lk_va = 32'h00AB_C123;
    @(negedge clk);
    rf_en = 0;
    check(!lk_hit, "R5 same-edge miss", lk_hit, 0);
    @(negedge clk);
    check(lk_hit && lk_pa == 32'h5555_5123, "R5 next-edge hit", lk_pa, 32'h5555_5123);
    // R3: offset pass-through and attributes
    check(lk_ap == 2'd3 && lk_c && !lk_b, "R3 attributes", {lk_ap, lk_c, lk_b}, 4'b1110);
    // R4: miss gives zeros
    look(32'hFFFF_F001, hit, pa);
    check(!hit && pa == 0 && lk_ap == 0 && !lk_c && !lk_b, "R4 miss zeros", {hit, pa}, 0);

    // R8: flush and refill same cycle -> refill dropped, all empty
    @(negedge clk);
    flush = 1; rf_en = 1; rf_vpn = 20'h00777; rf_pfn = 20'h1;
    @(negedge clk);
    flush = 0; rf_en = 0;
    look(32'h0077_7000, hit, pa);
    check(!hit, "R8 flush beats refill", hit, 0);
    look(32'h00AB_C123, hit, pa);
    check(!hit, "R8 flush empties", hit, 0);

    // R2, R5: fill all 64 entries, all hit
    for (int i = 0; i < N; i++) refill(vp(i), fr(i), 2'(i), i[0], i[1]);
    for (int i = 0; i < N; i++) begin
      look({vp(i), 12'h0F0}, hit, pa);
      check(hit && pa == {fr(i), 12'h0F0}, "R2 all 64 resident", pa, {fr(i), 12'h0F0});
    end

    // R6: full, pointer back at 0 -> evicts first filled
    refill(20'hC0001, 20'hD0001, 0, 0, 0);
    look({vp(0), 12'h0}, hit, pa);
    check(!hit, "R6 entry0 evicted", hit, 0);
    look({vp(1), 12'h0}, hit, pa);
    check(hit, "R6 entry1 kept", hit, 1);
    refill(20'hC0002, 20'hD0002, 0, 0, 0);
    look({vp(1), 12'h0}, hit, pa);
    check(!hit, "R6 entry1 evicted next", hit, 0);

    // R7: in-place overwrite of existing page (pointer now 2)
    refill(vp(5), 20'hEEEEE, 2'd1, 1, 1);
    look({vp(5), 12'h004}, hit, pa);
    check(hit && pa == 32'hEEEE_E004, "R7 overwrite in place", pa, 32'hEEEE_E004);
    look({vp(2), 12'h0}, hit, pa);
    check(hit, "R7 no eviction on duplicate", hit, 1);

    // R6: flush restores pointer to 0
    do_flush();
    for (int i = 0; i < N; i++) refill(vp(i), fr(i), 0, 0, 0);
    refill(20'hC0003, 20'hD0003, 0, 0, 0);
    look({vp(0), 12'h0}, hit, pa);
    check(!hit, "R6 pointer reset by flush", hit, 0);
    look({vp(1), 12'h0}, hit, pa);
    check(hit, "R6 pointer reset neighbour", hit, 1);
    look({20'hC0003, 12'h0}, hit, pa);
    check(hit && pa == 32'hD000_3000, "R6 new entry", pa, 32'hD000_3000);

    // R1: reset mid-run empties everything
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    look({vp(3), 12'h0}, hit, pa);
    check(!hit && pa == 0, "R1 reset empties", {hit, pa}, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog act=%0d exp=done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule